// File: doc/BRIEF.md
# Integer ALU with Set-Less-Than and Zero Flag

This block is a purely combinational integer arithmetic-logic unit of parameterised width. Its default is 32 bits. It is built from a row of identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate and a four-way output picker. The carries ripple from the least significant slice to the most significant one. A three-bit operation code selects between bitwise AND, bitwise OR, addition, subtraction and the signed set-less-than comparison. The top bit of the code inverts the B operand in every slice and injects a carry of one into bit 0. The low two bits choose which value each slice drives onto the result.

The signed comparison needs no comparator of its own. The subtraction runs as usual, and a sign judge at the top slice forms the "A is below B" decision. That decision is fed back into the spare picker input of bit 0. The same input is held at 0 in every other slice. Alongside the result, the unit reports a zero flag, the carry out of the top slice and signed overflow. A datapath uses the zero flag for equality branches and uses carry and overflow for arithmetic exceptions.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 drives the bitwise AND of A and B onto the result.
- R2: Code 3'b001 drives the bitwise OR of A and B onto the result.
- R3: Code 3'b010 drives (A + B) modulo 2^WIDTH onto the result. carry_o is the carry out of the most significant bit.
- R4: Code 3'b110 drives (A + ~B + 1) modulo 2^WIDTH onto the result. carry_o is the carry out of that sum, which is 1 exactly when A ≥ B unsigned.
- R5: Code 3'b111 drives 1 in result bit 0 when A < B as signed two's-complement numbers, and 0 otherwise. All other result bits are 0. The decision is correct even when A − B overflows.
- R6: zero_o is 1 exactly when every bit of result_o is 0. In particular, under code 3'b110 it is 1 exactly when A equals B.
- R7: Under code 3'b010, overflow_o is 1 exactly when A and B have the same sign bit and the sum has the other sign bit.
- R8: Under code 3'b110, overflow_o is 1 exactly when A ≥ 0 and B < 0 give a negative result, or when A < 0 and B ≥ 0 give a non-negative result.
- R9: Under codes 3'b000, 3'b001 and 3'b111, carry_o and overflow_o are both 0.
- R10: Codes 3'b011, 3'b100 and 3'b101 are unused. They drive a result of 0, carry_o = 0 and overflow_o = 0, so zero_o reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctl_i | input | 3 | Operation code: bit 2 negates B, bits 1:0 pick the slice output |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| carry_o | output | 1 | Carry out of the top slice for add and subtract |
| overflow_o | output | 1 | Signed overflow for add and subtract |

## Verification
The bench builds two copies of the unit. The first uses WIDTH = 4, which makes the whole space of eight codes and all operand pairs small enough to enumerate. That copy therefore reaches every carry pattern, every overflow sign combination, and every set-less-than case in which the subtraction overflows. The second copy uses the default WIDTH = 32. It is driven by a hand-made table of signed-boundary cases, such as the most negative value minus one and the all-ones operand plus one, followed by random operands under every code. Both copies are compared with a reference computed in wide signed integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_ctl_e;

  // Picker codes used inside each slice (low two bits of the control)
  localparam logic [1:0] PICK_AND  = 2'b00;
  localparam logic [1:0] PICK_OR   = 2'b01;
  localparam logic [1:0] PICK_SUM  = 2'b10;
  localparam logic [1:0] PICK_LESS = 2'b11;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // Signed overflow of a ripple adder: carry into the sign bit differs from carry out
  function automatic logic sign_overflow(input logic c_into_msb, input logic c_out_msb);
    return c_into_msb ^ c_out_msb;
  endfunction

  // True "less than" after a subtraction, corrected by overflow
  function automatic logic less_from_diff(input logic diff_sign, input logic ovf);
    return diff_sign ^ ovf;
  endfunction

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
  import alu_pkg::*;
(
  input  logic [2:0] ctl_i,
  output logic       b_negate_o,
  output logic [1:0] pick_o,
  output logic       legal_o,
  output logic       flags_en_o
);

  always_comb begin
    b_negate_o = ctl_i[2];
    pick_o     = ctl_i[1:0];
    legal_o    = 1'b0;
    flags_en_o = 1'b0;
    case (ctl_i)
      ALU_AND, ALU_OR, ALU_SLT: legal_o = 1'b1;
      ALU_ADD, ALU_SUB: begin
        legal_o    = 1'b1;
        flags_en_o = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       b_negate_i,
  input  logic       carry_i,
  input  logic       less_i,
  input  logic [1:0] pick_i,
  output logic       result_o,
  output logic       sum_o,
  output logic       carry_o
);

  logic b_eff;

  assign b_eff   = b_i ^ b_negate_i;
  assign sum_o   = fa_sum(a_i, b_eff, carry_i);
  assign carry_o = fa_carry(a_i, b_eff, carry_i);

  always_comb begin
    case (pick_i)
      PICK_AND: result_o = a_i & b_eff;
      PICK_OR:  result_o = a_i | b_eff;
      PICK_SUM: result_o = sum_o;
      default:  result_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_sign_judge.sv
module alu_sign_judge
  import alu_pkg::*;
(
  input  logic msb_carry_in_i,
  input  logic msb_carry_out_i,
  input  logic msb_sum_i,
  output logic ovf_o,
  output logic set_o
);

  assign ovf_o = sign_overflow(msb_carry_in_i, msb_carry_out_i);
  assign set_o = less_from_diff(msb_sum_i, ovf_o);

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  assign zero_o = (vec_i == '0);

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       ctl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             overflow_o
);

  localparam int MSB = WIDTH - 1;

  logic             b_negate;
  logic [1:0]       pick;
  logic             legal;
  logic             flags_en;
  logic             set_w;
  logic             ovf_raw;
  logic             cin_msb;
  logic             cout_msb;
  logic             sum_msb;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH-1:0] sum_w;

  alu_ctl_decode u_dec (
    .ctl_i      (ctl_i),
    .b_negate_o (b_negate),
    .pick_o     (pick),
    .legal_o    (legal),
    .flags_en_o (flags_en)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : gen_bit
    logic cin_g;
    logic cout_g;
    logic sum_g;
    logic res_g;
    logic less_g;
    if (i == 0) begin : g_lsb
      assign cin_g  = b_negate;
      assign less_g = set_w;
    end else begin : g_chain
      assign cin_g  = gen_bit[i-1].cout_g;
      assign less_g = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_i        (a_i[i]),
      .b_i        (b_i[i]),
      .b_negate_i (b_negate),
      .carry_i    (cin_g),
      .less_i     (less_g),
      .pick_i     (pick),
      .result_o   (res_g),
      .sum_o      (sum_g),
      .carry_o    (cout_g)
    );
    assign slice_res[i] = res_g;
    assign sum_w[i]     = sum_g;
  end

  assign cin_msb  = gen_bit[MSB].cin_g;
  assign cout_msb = gen_bit[MSB].cout_g;
  assign sum_msb  = gen_bit[MSB].sum_g;

  alu_sign_judge u_judge (
    .msb_carry_in_i  (cin_msb),
    .msb_carry_out_i (cout_msb),
    .msb_sum_i       (sum_msb),
    .ovf_o           (ovf_raw),
    .set_o           (set_w)
  );

  assign result_o   = legal ? slice_res : '0;
  assign carry_o    = flags_en & cout_msb;
  assign overflow_o = flags_en & ovf_raw;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       ctl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             carry_o,
  input logic             overflow_o,
  input logic [WIDTH-1:0] sum_w
);

  localparam int MSB = WIDTH - 1;

  logic is_arith;
  logic is_unused;

  assign is_arith  = (ctl_i == ALU_ADD) || (ctl_i == ALU_SUB);
  assign is_unused = (ctl_i == 3'b011) || (ctl_i == 3'b100) || (ctl_i == 3'b101);

  always_comb begin
    if (ctl_i == ALU_AND)
      AST_AND_BITS: assert ((result_o | a_i) == a_i && (result_o | b_i) == b_i) else $error("and"); // R1
    if (ctl_i == ALU_OR)
      AST_OR_COVERS: assert ((result_o & a_i) == a_i && (result_o & b_i) == b_i) else $error("or"); // R2
    if (is_arith)
      AST_ADDER_PATH: assert (result_o == sum_w) else $error("adder path"); // R3
    if (ctl_i == ALU_SUB)
      AST_SUB_EQUAL: assert (zero_o == (a_i == b_i)) else $error("sub equal"); // R6
    if (ctl_i == ALU_SLT)
      AST_SLT_NARROW: assert (result_o[MSB:1] == '0) else $error("slt upper"); // R5
    if (ctl_i == ALU_SLT && a_i[MSB] != b_i[MSB])
      AST_SLT_SIGN: assert (result_o[0] == a_i[MSB]) else $error("slt sign"); // R5
    if (ctl_i == ALU_ADD && a_i[MSB] != b_i[MSB])
      AST_ADD_NO_OVERFLOW: assert (!overflow_o) else $error("add ovf"); // R7
    if (ctl_i == ALU_SUB && a_i[MSB] == b_i[MSB])
      AST_SUB_NO_OVERFLOW: assert (!overflow_o) else $error("sub ovf"); // R8
    if (!is_arith)
      AST_QUIET_FLAGS: assert (!carry_o && !overflow_o) else $error("flags"); // R9
    if (is_unused)
      AST_UNUSED_ZERO: assert (result_o == '0 && zero_o) else $error("unused"); // R10
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .ctl_i      (ctl_i),
  .result_o   (result_o),
  .zero_o     (zero_o),
  .carry_o    (carry_o),
  .overflow_o (overflow_o),
  .sum_w      (sum_w)
);

// File: tb/alu_core_test.sv
module alu_core_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a32 = '0, b32 = '0, r32;
  logic [2:0]  c32 = '0;
  logic        z32, cy32, v32;
  logic [3:0]  a4 = '0, b4 = '0, r4;
  logic [2:0]  c4 = '0;
  logic        z4, cy4, v4;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  alu_core #(.WIDTH(32)) uut (
    .a_i(a32), .b_i(b32), .ctl_i(c32),
    .result_o(r32), .zero_o(z32), .carry_o(cy32), .overflow_o(v32)
  );

  alu_core #(.WIDTH(4)) uut_w4 (
    .a_i(a4), .b_i(b4), .ctl_i(c4),
    .result_o(r4), .zero_o(z4), .carry_o(cy4), .overflow_o(v4)
  );

  // {ctl, a, b, result, zero, carry, overflow}
  localparam int NV = 19;
  localparam logic [101:0] VECS [NV] = '{
    {3'b000, 32'hFFFF0000, 32'h0F0F0F0F, 32'h0F0F0000, 1'b0, 1'b0, 1'b0}, // R1
    {3'b001, 32'h00000D00, 32'h00003C00, 32'h00003D00, 1'b0, 1'b0, 1'b0}, // R2
    {3'b000, 32'h12345678, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R1 R6
    {3'b010, 32'h00000007, 32'h00000001, 32'h00000008, 1'b0, 1'b0, 1'b0}, // R3
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0, 1'b1}, // R7
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b1, 1'b0}, // R3
    {3'b010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 1'b1}, // R7
    {3'b110, 32'h00000007, 32'h00000006, 32'h00000001, 1'b0, 1'b1, 1'b0}, // R4
    {3'b110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b1, 1'b0}, // R6
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1}, // R8
    {3'b110, 32'h00000001, 32'h00000002, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0}, // R4
    {3'b110, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 1'b1}, // R8
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 1'b0}, // R5
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 1'b0}, // R5 overflowing
    {3'b111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R5 overflowing
    {3'b111, 32'h00000003, 32'h00000003, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R5
    {3'b100, 32'h0000FFFF, 32'h000000F0, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R10
    {3'b011, 32'h00000005, 32'h00000009, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R10
    {3'b101, 32'hAAAA5555, 32'h0F0F0F0F, 32'h00000000, 1'b1, 1'b0, 1'b0}  // R10
  };

  function automatic string res_req(input logic [2:0] ctl);
    case (ctl)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string cy_req(input logic [2:0] ctl);
    case (ctl)
      3'b010: return "R3";
      3'b110: return "R4";
      3'b000, 3'b001, 3'b111: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string ov_req(input logic [2:0] ctl);
    case (ctl)
      3'b010: return "R7";
      3'b110: return "R8";
      3'b000, 3'b001, 3'b111: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Independent reference in wide signed arithmetic
  task automatic ref_alu(input int w, input logic [2:0] ctl,
                         input longint unsigned a, input longint unsigned b,
                         output longint unsigned res, output bit z, output bit c, output bit v);
    longint unsigned mask, t;
    longint sa, sb, d, smax, smin;
    mask = (64'd1 << w) - 1;
    sa = a[w-1] ? longint'(a) - longint'(64'd1 << w) : longint'(a);
    sb = b[w-1] ? longint'(b) - longint'(64'd1 << w) : longint'(b);
    smax = longint'(64'd1 << (w-1)) - 1;
    smin = -longint'(64'd1 << (w-1));
    res = 0; c = 0; v = 0;
    case (ctl)
      3'b000: res = a & b;
      3'b001: res = a | b;
      3'b010: begin
        t = a + b; res = t & mask; c = ((t >> w) & 1) != 0;
        d = sa + sb; v = (d > smax) || (d < smin);
      end
      3'b110: begin
        t = a + ((~b) & mask) + 1; res = t & mask; c = ((t >> w) & 1) != 0;
        d = sa - sb; v = (d > smax) || (d < smin);
      end
      3'b111: res = (sa < sb) ? 1 : 0;
      default: res = 0;
    endcase
    z = (res == 0);
  endtask

  task automatic judge(input string where, input logic [2:0] ctl,
                       input longint unsigned gr, input longint unsigned er,
                       input bit gz, input bit ez, input bit gc, input bit ec,
                       input bit gv, input bit ev);
    bit bad = 0;
    vectors++;
    if (gr != er) begin
      bad = 1;
      $display("FAIL %s %s result ctl=%b got %h exp %h", where, res_req(ctl), ctl, gr, er);
    end
    if (gz != ez) begin
      bad = 1;
      $display("FAIL %s R6 zero ctl=%b got %0d exp %0d", where, ctl, gz, ez);
    end
    if (gc != ec) begin
      bad = 1;
      $display("FAIL %s %s carry ctl=%b got %0d exp %0d", where, cy_req(ctl), ctl, gc, ec);
    end
    if (gv != ev) begin
      bad = 1;
      $display("FAIL %s %s overflow ctl=%b got %0d exp %0d", where, ov_req(ctl), ctl, gv, ev);
    end
    if (bad) miscompares++;
  endtask

  task automatic drive32(input logic [2:0] ctl, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    c32 = ctl; a32 = a; b32 = b;
    @(negedge clk);
  endtask

  initial begin
    longint unsigned er;
    bit ez, ec, ev;
    logic [2:0] codes [8];

    // Idle state: AND of zeros gives zero result with the zero flag set (R1, R6)
    @(negedge clk);
    judge("idle32", 3'b000, r32, 0, z32, 1, cy32, 0, v32, 0);
    judge("idle4", 3'b000, r4, 0, z4, 1, cy4, 0, v4, 0);

    // Table of directed 32-bit vectors
    for (int i = 0; i < NV; i++) begin
      drive32(VECS[i][101:99], VECS[i][98:67], VECS[i][66:35]);
      judge("table32", VECS[i][101:99], r32, VECS[i][34:3], z32, VECS[i][2],
            cy32, VECS[i][1], v32, VECS[i][0]);
    end

    // Exhaustive 4-bit sweep: every code and operand pair (R1..R10)
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          c4 = 3'(c); a4 = 4'(a); b4 = 4'(b);
          @(negedge clk);
          ref_alu(4, 3'(c), longint'(a), longint'(b), er, ez, ec, ev);
          judge("sweep4", 3'(c), longint'(r4), er, z4, ez, cy4, ec, v4, ev);
        end
      end
    end

    // Random 32-bit operands under every code, with signed-edge biasing
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 400; n++) begin
        logic [31:0] ra, rb;
        ra = $urandom;
        rb = $urandom;
        if (n % 7 == 0) rb = ra;
        if (n % 11 == 0) ra = {1'b1, 31'h0} ^ (ra & 32'h3);
        if (n % 13 == 0) rb = {1'b0, {31{1'b1}}} ^ (rb & 32'h3);
        drive32(3'(c), ra, rb);
        ref_alu(32, 3'(c), longint'(ra), longint'(rb), er, ez, ec, ev);
        judge("rand32", 3'(c), longint'(r32), er, z32, ez, cy32, ec, v32, ev);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before the run ended");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule